// File: doc/BRIEF.md
# Platform Power State Sequencer

This block walks an application processor and its PMIC through the platform power states: fully off (G3), standby (S5), suspended (S3) and running (S0). It also handles the transient states between them. It watches PMIC power-good, the processor's suspend indicator and the processor's active-low watchdog line. It acts on a boot request, a forced-off request and a held power button. Its outputs are an active-low PMIC enable that behaves like a power key, an active-low system reset, an active-low PMIC watchdog override and a mask that tells surrounding logic to ignore the watchdog line.

All delays are counted in ticks of a one-cycle `ms_tick` strobe, nominally one per millisecond. Power-up pulses the PMIC enable when the rails are down. Each stage of power-up has a bounded wait, and a failed stage is retried once before the sequencer gives up and returns to G3. A forced shutdown that reaches standby with the rails still up holds the PMIC enable low, like a long key press, until the PMIC drops power-good.

Top module: `pwr_state_seq`

## Requirements
- R1: Reset is synchronous and active low. While in reset, and for the first cycle after it, the state is G3 when `pmic_pgood` is low and S5 when it is high. The outputs are `pmic_en_n`=1, `sys_rst_n`=0, `pmic_wdt_n`=1 and `wdt_mask`=1. Whenever the state is G3, `wdt_mask`=1 and `sys_rst_n`=0.
- R2: In G3, `boot_req` moves the state through G3S5 to S5 and clears any pending forced shutdown. In G3, a high `pmic_pgood` moves the state to S5G3 instead, and this takes priority over `boot_req`. In S5 with no forced shutdown pending, power-up starts (state PREP), `pmic_wdt_n` returns to 1 and the single-retry flag is armed.
- R3: In PREP with `pmic_pgood` low, `pmic_en_n` stays 1 for PULSE_MS ticks. Then it is 0 for PULSE_MS ticks (state PULSE), and then it returns to 1 as the state enters PGWAIT. In PREP with `pmic_pgood` high, the state goes straight to PGWAIT.
- R4: PGWAIT ends when `pmic_pgood` is high. If PG_WAIT_MS ticks pass first, the sequencer goes back to PREP the first time and to S5G3 the second time. When `pmic_pgood` rises in the same cycle as the expiry, power-good wins.
- R5: When PGWAIT ends on power-good, the state enters WDWAIT with `sys_rst_n`=1 and `wdt_mask`=0. The state moves to S3 when `ap_wdt_n` is high. After WDT_WAIT_MS ticks with no high `ap_wdt_n`, the same one-retry rule as in R4 applies.
- R6: S3 goes to S0 when `ap_suspend` is 0. S0 goes through S0S3 back to S3 when `ap_suspend` is 1, `pmic_pgood` is 0, or a forced shutdown is pending.
- R7: S3 goes to S3S5 when `pmic_pgood` is 0 or a forced shutdown is pending, and `sys_rst_n` falls as S3S5 is entered. S3S5 moves to S5 with `wdt_mask`=1 once `ap_wdt_n` is 0. If WDT_WAIT_MS ticks pass first, it moves to S5 with `pmic_wdt_n` driven to 0.
- R8: A pulse on `force_off_req` makes a forced shutdown pending. In S5 with a forced shutdown pending and `pmic_pgood` high, the state stays S5 and `pmic_en_n` is held at 0. When `pmic_pgood` falls, the state goes to S5G3 with `pmic_en_n`=1, and then to G3.
- R9: S5G3 returns to S5 when `pmic_pgood` is high and enters G3 when it is low.
- R10: If `pwr_btn_held` is 1 in S0S3, a forced shutdown becomes pending at once. The path then runs S3, S3S5, S5 and the long-press hold.
- R11: When S3 is left because `pmic_pgood` dropped, the sequencer passes through S5 and S5G3 to G3 without starting a power-up.
- R12: `state_o` encodes the states as follows: G3=0, S5=1, S3=2, S0=3, G3S5=4, PREP=5, PULSE=6, PGWAIT=7, WDWAIT=8, S3S5=9, S5G3=10, S0S3=11. Every wait counter restarts from zero on each state entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| pmic_pgood | input | 1 | PMIC power-good, high when rails are up |
| ap_suspend | input | 1 | High while the processor is suspended |
| ap_wdt_n | input | 1 | Processor watchdog line, low when asserted |
| boot_req | input | 1 | Request to power up from G3 |
| force_off_req | input | 1 | Pulse requesting a forced shutdown |
| pwr_btn_held | input | 1 | High while the power button is held |
| pmic_en_n | output | 1 | Active-low PMIC enable (power key) |
| sys_rst_n | output | 1 | Active-low system reset to the processor |
| pmic_wdt_n | output | 1 | Active-low PMIC watchdog override |
| wdt_mask | output | 1 | High while the watchdog line must be ignored |
| state_o | output | 4 | Current state, encoded per R12 |

## Verification
The arrival of power-good and the expiry of the power-good window can fall in the same cycle. The bench sweeps the arrival of `pmic_pgood` across every tick of the window. The last case raises power-good between the tick that fills the counter and the edge on which the sequencer compares it. In each case the bench expects WDWAIT with reset released and the watchdog unmasked, and never a retry. The expected state at every step comes from a count of ticks and register stages made in the bench.

// File: rtl/pwrseq_pkg.sv
// Package: state encoding shared by the sequencer and its bench-visible output.
// Assumes a 4-bit state field; the numeric values are part of the interface.
package pwrseq_pkg;
    typedef enum logic [3:0] {
        ST_G3     = 4'd0,
        ST_S5     = 4'd1,
        ST_S3     = 4'd2,
        ST_S0     = 4'd3,
        ST_G3S5   = 4'd4,
        ST_PREP   = 4'd5,
        ST_PULSE  = 4'd6,
        ST_PGWAIT = 4'd7,
        ST_WDWAIT = 4'd8,
        ST_S3S5   = 4'd9,
        ST_S5G3   = 4'd10,
        ST_S0S3   = 4'd11
    } pwr_state_e;
endpackage

// File: rtl/pwrseq_tick_timer.sv
// Module: saturating count of millisecond ticks since the last clear.
// Assumes clr is high for the cycle in which a new state is entered.
module pwrseq_tick_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    // Count ticks, restart on clear, hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (ms_tick && (cnt != {CNT_W{1'b1}}))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwrseq_fsm.sv
// Module: power state machine with its control flags and registered outputs.
// Assumes cnt counts ticks since the current state was entered (cleared via
// tmr_clr) and that every limit fits in CNT_W bits.
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int PULSE_MS    = 50,
    parameter int PG_WAIT_MS  = 300,
    parameter int WDT_WAIT_MS = 100,
    parameter int CNT_W       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pmic_pgood,
    input  logic             ap_suspend,
    input  logic             ap_wdt_n,
    input  logic             boot_req,
    input  logic             force_off_req,
    input  logic             pwr_btn_held,
    input  logic [CNT_W-1:0] cnt,
    output logic             tmr_clr,
    output logic [3:0]       state_o,
    output logic             pmic_en_n,
    output logic             sys_rst_n,
    output logic             pmic_wdt_n,
    output logic             wdt_mask
);
    localparam logic [CNT_W-1:0] LIM_PULSE = CNT_W'(PULSE_MS);
    localparam logic [CNT_W-1:0] LIM_PG    = CNT_W'(PG_WAIT_MS);
    localparam logic [CNT_W-1:0] LIM_WDT   = CNT_W'(WDT_WAIT_MS);

    pwr_state_e state_q, state_d;
    logic forcing_q, forcing_d;   // forced shutdown pending
    logic retry_q, retry_d;       // one retry left in power-up
    logic ap_off_q, ap_off_d;     // PMIC dropped rails on its own
    logic hold_q, hold_d;         // long-press hold of the PMIC enable
    logic rel_q, rel_d;           // system reset released
    logic mask_q, mask_d;         // watchdog line masked
    logic pwdt_q, pwdt_d;         // PMIC watchdog override (active low)

    // Next state and flag updates for every state.
    always_comb begin
        state_d   = state_q;
        forcing_d = forcing_q | force_off_req;
        retry_d   = retry_q;
        ap_off_d  = ap_off_q;
        hold_d    = hold_q;
        rel_d     = rel_q;
        mask_d    = mask_q;
        pwdt_d    = pwdt_q;
        case (state_q)
            ST_G3: begin
                if (pmic_pgood)    state_d = ST_S5G3;
                else if (boot_req) state_d = ST_G3S5;
            end
            ST_G3S5: begin
                forcing_d = force_off_req;
                state_d   = ST_S5;
            end
            ST_S5: begin
                if (ap_off_q) begin
                    ap_off_d = 1'b0;
                    state_d  = ST_S5G3;
                end else if (!forcing_q) begin
                    retry_d = 1'b1;
                    hold_d  = 1'b0;
                    pwdt_d  = 1'b1;
                    state_d = ST_PREP;
                end else if (!pmic_pgood) begin
                    hold_d  = 1'b0;
                    state_d = ST_S5G3;
                end else begin
                    hold_d = 1'b1;
                end
            end
            ST_PREP: begin
                if (pmic_pgood)             state_d = ST_PGWAIT;
                else if (cnt >= LIM_PULSE)  state_d = ST_PULSE;
            end
            ST_PULSE: begin
                if (cnt >= LIM_PULSE) state_d = ST_PGWAIT;
            end
            ST_PGWAIT: begin
                if (pmic_pgood) begin
                    rel_d   = 1'b1;
                    mask_d  = 1'b0;
                    state_d = ST_WDWAIT;
                end else if (cnt >= LIM_PG) begin
                    retry_d = 1'b0;
                    state_d = retry_q ? ST_PREP : ST_S5G3;
                end
            end
            ST_WDWAIT: begin
                if (ap_wdt_n) begin
                    state_d = ST_S3;
                end else if (cnt >= LIM_WDT) begin
                    retry_d = 1'b0;
                    state_d = retry_q ? ST_PREP : ST_S5G3;
                end
            end
            ST_S3: begin
                if (!pmic_pgood || forcing_q) begin
                    ap_off_d = !pmic_pgood;
                    rel_d    = 1'b0;
                    state_d  = ST_S3S5;
                end else if (!ap_suspend) begin
                    state_d = ST_S0;
                end
            end
            ST_S0: begin
                if (!pmic_pgood || forcing_q || ap_suspend) state_d = ST_S0S3;
            end
            ST_S0S3: begin
                if (pwr_btn_held) forcing_d = 1'b1;
                state_d = ST_S3;
            end
            ST_S3S5: begin
                if (!ap_wdt_n) begin
                    mask_d  = 1'b1;
                    state_d = ST_S5;
                end else if (cnt >= LIM_WDT) begin
                    pwdt_d  = 1'b0;
                    mask_d  = 1'b1;
                    state_d = ST_S5;
                end
            end
            ST_S5G3: begin
                hold_d  = 1'b0;
                rel_d   = 1'b0;
                mask_d  = 1'b1;
                state_d = pmic_pgood ? ST_S5 : ST_G3;
            end
            default: state_d = ST_G3;
        endcase
    end

    // State and flag registers; start state follows power-good at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= pmic_pgood ? ST_S5 : ST_G3;
            forcing_q <= 1'b0;
            retry_q   <= 1'b0;
            ap_off_q  <= 1'b0;
            hold_q    <= 1'b0;
            rel_q     <= 1'b0;
            mask_q    <= 1'b1;
            pwdt_q    <= 1'b1;
        end else begin
            state_q   <= state_d;
            forcing_q <= forcing_d;
            retry_q   <= retry_d;
            ap_off_q  <= ap_off_d;
            hold_q    <= hold_d;
            rel_q     <= rel_d;
            mask_q    <= mask_d;
            pwdt_q    <= pwdt_d;
        end
    end

    // Output mapping: the key is pressed during the pulse or the long hold.
    always_comb begin
        tmr_clr    = (state_d != state_q);
        state_o    = state_q;
        pmic_en_n  = !((state_q == ST_PULSE) || hold_q);
        sys_rst_n  = rel_q;
        pmic_wdt_n = pwdt_q;
        wdt_mask   = mask_q;
    end

    // R1
    off_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_G3) |-> (wdt_mask && !sys_rst_n));

    // R3
    pulse_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |=> (state_q == ST_PULSE || state_q == ST_PGWAIT));

    // R4
    giveup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PGWAIT && !pmic_pgood && cnt >= LIM_PG && !retry_q)
        |=> (state_q == ST_S5G3));

    // R5
    s3_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S3) |-> (sys_rst_n && !wdt_mask));

    // R6
    s0_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S0 && ap_suspend) |=> (state_q == ST_S0S3));

    // R8
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S5 && forcing_q && !ap_off_q && pmic_pgood)
        |=> (state_q == ST_S5 && !pmic_en_n));

    // R9
    s5g3_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S5G3 && pmic_pgood) |=> (state_q == ST_S5));
endmodule

// File: rtl/pwr_state_seq.sv
// Module: top of the power sequencer; ties the tick timer to the state machine.
// Assumes ms_tick is a single-cycle strobe and all inputs are synchronous.
module pwr_state_seq #(
    parameter int PULSE_MS    = 50,
    parameter int PG_WAIT_MS  = 300,
    parameter int WDT_WAIT_MS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       pmic_pgood,
    input  logic       ap_suspend,
    input  logic       ap_wdt_n,
    input  logic       boot_req,
    input  logic       force_off_req,
    input  logic       pwr_btn_held,
    output logic       pmic_en_n,
    output logic       sys_rst_n,
    output logic       pmic_wdt_n,
    output logic       wdt_mask,
    output logic [3:0] state_o
);
    localparam int MAX_A  = (PULSE_MS > PG_WAIT_MS) ? PULSE_MS : PG_WAIT_MS;
    localparam int MAX_MS = (MAX_A > WDT_WAIT_MS) ? MAX_A : WDT_WAIT_MS;
    localparam int CNT_W  = $clog2(MAX_MS + 1);

    logic [CNT_W-1:0] cnt;
    logic             tmr_clr;

    pwrseq_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .clr     (tmr_clr),
        .cnt     (cnt)
    );

    pwrseq_fsm #(
        .PULSE_MS    (PULSE_MS),
        .PG_WAIT_MS  (PG_WAIT_MS),
        .WDT_WAIT_MS (WDT_WAIT_MS),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pmic_pgood    (pmic_pgood),
        .ap_suspend    (ap_suspend),
        .ap_wdt_n      (ap_wdt_n),
        .boot_req      (boot_req),
        .force_off_req (force_off_req),
        .pwr_btn_held  (pwr_btn_held),
        .cnt           (cnt),
        .tmr_clr       (tmr_clr),
        .state_o       (state_o),
        .pmic_en_n     (pmic_en_n),
        .sys_rst_n     (sys_rst_n),
        .pmic_wdt_n    (pmic_wdt_n),
        .wdt_mask      (wdt_mask)
    );
endmodule

// File: tb/tb_pwr_state_seq.sv
// Bench: walks every transition path with short windows and sweeps the
// arrival of power-good over the whole power-good window.
module tb_pwr_state_seq;
    localparam int PULSE = 3;
    localparam int PGW   = 6;
    localparam int WDTW  = 4;

    localparam int G3 = 0, S5 = 1, S3 = 2, S0 = 3, G3S5 = 4, PREP = 5,
                   PULS = 6, PGWT = 7, WDWT = 8, S3S5 = 9, S5G3 = 10, S0S3 = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, pmic_pgood = 1'b0, ap_suspend = 1'b1, ap_wdt_n = 1'b0;
    logic boot_req = 1'b0, force_off_req = 1'b0, pwr_btn_held = 1'b0;
    logic pmic_en_n, sys_rst_n, pmic_wdt_n, wdt_mask;
    logic [3:0] state_o;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwr_state_seq #(.PULSE_MS(PULSE), .PG_WAIT_MS(PGW), .WDT_WAIT_MS(WDTW)) dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pmic_pgood(pmic_pgood),
        .ap_suspend(ap_suspend), .ap_wdt_n(ap_wdt_n), .boot_req(boot_req),
        .force_off_req(force_off_req), .pwr_btn_held(pwr_btn_held),
        .pmic_en_n(pmic_en_n), .sys_rst_n(sys_rst_n), .pmic_wdt_n(pmic_wdt_n),
        .wdt_mask(wdt_mask), .state_o(state_o));

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            step();
            ms_tick = 1'b0;
            step();
        end
    endtask

    // From G3 with pgood low: boot, pulse, then power-good after k ticks.
    task automatic bring_up(input int k);
        boot_req = 1'b1;
        step();
        boot_req = 1'b0;
        step();
        step();
        tick(PULSE);
        tick(PULSE);
        if (k < PGW) begin
            tick(k);
            pmic_pgood = 1'b1;
            step();
        end else begin
            tick(PGW - 1);
            ms_tick = 1'b1;
            step();
            ms_tick = 1'b0;
            pmic_pgood = 1'b1;
            step();
        end
    endtask

    // From S3: forced shutdown through S5 hold to G3.
    task automatic go_off();
        force_off_req = 1'b1;
        ap_wdt_n = 1'b0;
        step();
        force_off_req = 1'b0;
        step();
        step();
        step();
        pmic_pgood = 1'b0;
        step();
        step();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset with power-good high then low.
        pmic_pgood = 1'b1;
        step();
        chk("R1 reset S5", state_o, S5);
        pmic_pgood = 1'b0;
        step();
        step();
        chk("R1 reset G3", state_o, G3);
        chk("R1 en_n", pmic_en_n, 1);
        chk("R1 sys_rst_n", sys_rst_n, 0);
        chk("R1 pmic_wdt_n", pmic_wdt_n, 1);
        chk("R1 mask", wdt_mask, 1);
        rst_n = 1'b1;
        step();
        chk("R1 idle G3", state_o, G3);

        // R2 and R12: boot path.
        boot_req = 1'b1;
        step();
        boot_req = 1'b0;
        chk("R12 G3S5 code", state_o, G3S5);
        step();
        chk("R2 S5", state_o, S5);
        step();
        chk("R2 PREP", state_o, PREP);

        // R3: enable pulse timing.
        tick(PULSE - 1);
        chk("R3 pre-wait", state_o, PREP);
        chk("R3 en high before pulse", pmic_en_n, 1);
        tick(1);
        chk("R3 pulse state", state_o, PULS);
        chk("R3 en low", pmic_en_n, 0);
        tick(PULSE - 1);
        chk("R3 en still low", pmic_en_n, 0);
        tick(1);
        chk("R3 PGWAIT", state_o, PGWT);
        chk("R3 en released", pmic_en_n, 1);

        // R4: timeout retries once, then gives up.
        tick(PGW - 1);
        chk("R4 still waiting", state_o, PGWT);
        tick(1);
        chk("R4 retry", state_o, PREP);
        tick(PULSE);
        tick(PULSE);
        tick(PGW);
        chk("R4 give up", state_o, S5G3);
        step();
        chk("R9 S5G3 to G3", state_o, G3);

        // R4 and R5: sweep power-good arrival over the window, incl. expiry cycle.
        for (int k = 0; k <= PGW; k++) begin
            bring_up(k);
            chk($sformatf("R4 pg at tick %0d", k), state_o, WDWT);
            chk("R5 reset released", sys_rst_n, 1);
            chk("R5 unmasked", wdt_mask, 0);
            ap_wdt_n = 1'b1;
            step();
            chk("R5 S3", state_o, S3);
            go_off();
            chk("R8 forced off G3", state_o, G3);
        end

        // R6 and R11: run, suspend, then PMIC drops rails.
        bring_up(0);
        ap_wdt_n = 1'b1;
        step();
        ap_suspend = 1'b0;
        step();
        chk("R6 S0", state_o, S0);
        ap_suspend = 1'b1;
        step();
        chk("R6 S0S3", state_o, S0S3);
        step();
        chk("R6 S3", state_o, S3);
        ap_suspend = 1'b0;
        step();
        pmic_pgood = 1'b0;
        step();
        chk("R6 pgood loss", state_o, S0S3);
        step();
        step();
        chk("R7 S3S5", state_o, S3S5);
        chk("R7 reset asserted", sys_rst_n, 0);
        tick(WDTW - 1);
        chk("R7 waiting wdt", state_o, S3S5);
        tick(1);
        chk("R7 timeout S5", state_o, S5);
        chk("R7 override low", pmic_wdt_n, 0);
        chk("R7 masked", wdt_mask, 1);
        step();
        chk("R11 S5G3", state_o, S5G3);
        step();
        chk("R11 G3", state_o, G3);
        chk("R11 en_n", pmic_en_n, 1);

        // R2, R9, R5: pgood rises in G3; watchdog never releases.
        ap_suspend = 1'b1;
        ap_wdt_n = 1'b0;
        pmic_pgood = 1'b1;
        boot_req = 1'b1;
        step();
        boot_req = 1'b0;
        chk("R2 G3 pgood", state_o, S5G3);
        step();
        chk("R9 back to S5", state_o, S5);
        step();
        chk("R2 override restored", pmic_wdt_n, 1);
        step();
        chk("R3 skip pulse", state_o, PGWT);
        step();
        chk("R5 WDWAIT", state_o, WDWT);
        tick(WDTW);
        chk("R5 wdt retry", state_o, PREP);
        step();
        step();
        tick(WDTW);
        chk("R5 wdt give up", state_o, S5G3);
        pmic_pgood = 1'b0;
        step();
        chk("R1 G3 after give up", state_o, G3);
        chk("R1 mask in G3", wdt_mask, 1);
        chk("R1 reset in G3", sys_rst_n, 0);

        // R10 and R8: button held while suspending from S0.
        bring_up(1);
        ap_wdt_n = 1'b1;
        step();
        ap_suspend = 1'b0;
        step();
        chk("R10 S0", state_o, S0);
        pwr_btn_held = 1'b1;
        ap_suspend = 1'b1;
        step();
        step();
        chk("R10 S3", state_o, S3);
        step();
        chk("R10 forced S3S5", state_o, S3S5);
        ap_wdt_n = 1'b0;
        step();
        chk("R10 S5", state_o, S5);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R8 hold state", state_o, S5);
            chk("R8 hold en low", pmic_en_n, 0);
        end
        pmic_pgood = 1'b0;
        step();
        chk("R8 S5G3", state_o, S5G3);
        chk("R8 en released", pmic_en_n, 1);
        step();
        chk("R8 G3", state_o, G3);
        pwr_btn_held = 1'b0;

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule